// File: doc/BRIEF.md
# Three-Wire Serial Register Load Interface

This block receives configuration words over a three-wire serial link made of a serial clock, a serial data line and a latch line. It moves each word into one of a set of internal 20-bit control registers. While the latch line is low, each rising edge of the serial clock shifts one data bit into a 24-bit holding register, most significant bit first. When the latch line rises, the four bits shifted in last are used as an address. The twenty bits before them are then copied into the register at that address.

All three serial lines are asynchronous to the system clock. Each line passes through a two-stage synchronizer, and its edges are detected in the system clock domain, so the serial clock must run a few times slower than the system clock. Two registers have side effects.
- Every write to the calibration register (address 0) produces a one-cycle calibration-start pulse, even when the written value is the same as before.
- The power register (address 5) holds the power-enable bits and a soft-reset bit. Setting the soft-reset bit returns every register to its default value.

Top module: `sreg_load_if`

## Requirements
- R1: On each rising edge of `ser_clk` while `ser_latch` is low, the holding register shifts left and takes `ser_data` into bit 0, so the word is sent most significant bit first. Rising edges of `ser_clk` while `ser_latch` is high do not change the holding register.
- R2: On a rising edge of `ser_latch`, bits [23:4] of the holding register are written into the slot addressed by bits [3:0]. Slot n appears on `regs_flat[20n+19:20n]`. No slot changes at any other time.
- R3: Only addresses 0 to 9 and 12 have registers. A write to address 10, 11, 13, 14 or 15 changes nothing, and those slots always read as zero.
- R4: When more than 24 bits are shifted before the latch rises, only the last 24 bits are kept.
- R5: Each accepted write to address 0 gives `cal_start` high for exactly one system clock, even when the value written is unchanged. Writes to other addresses give no pulse.
- R6: A write to address 5 with data bit 19 set returns every register to its default value and sets `soft_rst` high. Slot 5 then reads 0x80000, and `pwr_en` reads zero.
- R7: While `soft_rst` is high, a write to address 5 with bit 19 clear clears `soft_rst` and leaves slot 5 at zero. A later write to address 5 is needed to set the enable bits.
- R8: While `soft_rst` is high, writes to every other address are ignored, and no `cal_start` pulse is produced.
- R9: After system reset, slot 5 is zero and every other implemented slot n holds n in data bits [19:16] with all other bits zero. `soft_rst` and `cal_start` are low.
- R10: `pwr_en[6:0]` equals slot 5 bits [6:0]. The bits are, from 0 up: PLL, VCO, oscillator, VCO regulator, PLL regulator, digital regulator, loop filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first, asynchronous |
| ser_latch | input | 1 | Latch line; its rising edge commits the word |
| regs_flat | output | 320 | All 16 register slots, slot n at bits [20n+19:20n] |
| pwr_en | output | 7 | Power-enable bits taken from slot 5 |
| soft_rst | output | 1 | Soft reset is being held (slot 5 bit 19) |
| cal_start | output | 1 | One-cycle pulse on each accepted write to address 0 |

## Verification
The assertions check on every cycle that register contents move only in the cycle after a write strobe, and that `cal_start` is a single-cycle pulse traced back to a write of address 0. They also check that `pwr_en` stays zero while soft reset is held, and that no pulse appears and no register changes during soft reset except the release itself. Several behaviours can only be shown by the bench's scenarios, because each depends on a serial sequence:
- MSB-first assembly with the address taken from the tail of the word
- keeping only the last 24 bits of an over-long stream
- ignoring shift clocks while the latch is high
- the defaults after each kind of reset
- the two-step release-then-enable order

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SR_WORD_W    = 24;
  localparam int SR_ADDR_W    = 4;
  localparam int SR_DATA_W    = SR_WORD_W - SR_ADDR_W;
  localparam int SR_SLOTS     = 1 << SR_ADDR_W;
  localparam int SR_CAL_ADDR  = 0;
  localparam int SR_PWR_ADDR  = 5;
  localparam int SR_SRST_BIT  = 19;
  localparam int SR_PWR_BITS  = 7;
  localparam logic [SR_SLOTS-1:0] SR_IMPL_MASK = 16'h13FF;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 4,
  localparam int DATA_W = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_sclk,
  input  logic              s_sdat,
  input  logic              s_latch,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              sclk_d;
  logic              latch_d;
  logic [WORD_W-1:0] hold_q;
  logic              sclk_rise;
  logic              latch_rise;

  assign sclk_rise  = s_sclk & ~sclk_d;
  assign latch_rise = s_latch & ~latch_d;

  // Previous-value flops reset high so that no edge is seen right after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b1;
      latch_d <= 1'b1;
    end else begin
      sclk_d  <= s_sclk;
      latch_d <= s_latch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (sclk_rise && !s_latch) begin
      hold_q <= {hold_q[WORD_W-2:0], s_sdat};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= latch_rise;
      if (latch_rise) begin
        wr_addr <= hold_q[ADDR_W-1:0];
        wr_data <= hold_q[WORD_W-1:ADDR_W];
      end
    end
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 20,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 'h13FF,
  parameter int CAL_ADDR = 0,
  parameter int PWR_ADDR = 5,
  parameter int SRST_BIT = 19,
  parameter int PWR_BITS = 7,
  localparam int SLOTS   = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_stb,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [SLOTS*DATA_W-1:0] regs_flat,
  output logic [PWR_BITS-1:0]     pwr_en,
  output logic                    soft_rst,
  output logic                    cal_start
);
  localparam logic [DATA_W-1:0] SRST_ONLY = DATA_W'(1) << SRST_BIT;

  function automatic logic [DATA_W-1:0] slot_default(input int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx != PWR_ADDR) v[DATA_W-1 -: ADDR_W] = ADDR_W'(idx);
    return v;
  endfunction

  logic in_srst;
  logic hit_srst;

  assign in_srst  = regs_flat[PWR_ADDR*DATA_W + SRST_BIT];
  assign hit_srst = wr_stb && (wr_addr == ADDR_W'(PWR_ADDR)) && wr_data[SRST_BIT];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (IMPL_MASK[i]) begin : g_impl
      localparam logic [DATA_W-1:0] DEF = slot_default(i);
      localparam logic [DATA_W-1:0] SRST_VAL = (i == PWR_ADDR) ? (DEF | SRST_ONLY) : DEF;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= DEF;
        end else if (wr_stb) begin
          if (in_srst) begin
            // held in soft reset: only the release write to the power slot acts
            if ((i == PWR_ADDR) && (wr_addr == ADDR_W'(i)) && !wr_data[SRST_BIT]) q <= DEF;
          end else if (hit_srst) begin
            q <= SRST_VAL;
          end else if (wr_addr == ADDR_W'(i)) begin
            q <= wr_data;
          end
        end
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
    end else begin : g_empty
      assign regs_flat[i*DATA_W +: DATA_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cal_start <= 1'b0;
    else     cal_start <= wr_stb && (wr_addr == ADDR_W'(CAL_ADDR)) && !in_srst;
  end

  assign pwr_en   = regs_flat[PWR_ADDR*DATA_W +: PWR_BITS];
  assign soft_rst = in_srst;
endmodule

// File: rtl/sreg_load_if.sv
module sreg_load_if
  import sreg_pkg::*;
#(
  parameter int WORD_W      = SR_WORD_W,
  parameter int ADDR_W      = SR_ADDR_W,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = SR_IMPL_MASK,
  parameter int CAL_ADDR    = SR_CAL_ADDR,
  parameter int PWR_ADDR    = SR_PWR_ADDR,
  parameter int SRST_BIT    = SR_SRST_BIT,
  parameter int PWR_BITS    = SR_PWR_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_latch,
  output logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0] regs_flat,
  output logic [PWR_BITS-1:0] pwr_en,
  output logic soft_rst,
  output logic cal_start
);
  localparam int DATA_W = WORD_W - ADDR_W;

  logic [2:0]        s_lines;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_latch, ser_data, ser_clk}),
    .q   (s_lines)
  );

  sreg_shifter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_shift (
    .clk     (clk),
    .rst     (rst),
    .s_sclk  (s_lines[0]),
    .s_sdat  (s_lines[1]),
    .s_latch (s_lines[2]),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  sreg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .CAL_ADDR(CAL_ADDR),
    .PWR_ADDR(PWR_ADDR), .SRST_BIT(SRST_BIT), .PWR_BITS(PWR_BITS)
  ) i_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs_flat (regs_flat),
    .pwr_en    (pwr_en),
    .soft_rst  (soft_rst),
    .cal_start (cal_start)
  );
endmodule

// File: rtl/sreg_load_if_chk.sv
module sreg_load_if_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 20,
  parameter int CAL_ADDR = 0,
  parameter int PWR_BITS = 7
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_stb,
  input logic [ADDR_W-1:0]              wr_addr,
  input logic                           cal_start,
  input logic                           soft_rst,
  input logic [PWR_BITS-1:0]            pwr_en,
  input logic [(1<<ADDR_W)*DATA_W-1:0]  regs_flat
);
  assert_cal_single_R5: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);

  assert_cal_source_R5: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> $past(wr_stb && (wr_addr == ADDR_W'(CAL_ADDR))));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_stb) |-> $stable(regs_flat));

  assert_srst_power_off_R6: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (pwr_en == '0));

  assert_srst_no_cal_R8: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> !cal_start);

  assert_srst_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && $past(soft_rst)) |-> $stable(regs_flat));
endmodule

bind sreg_load_if sreg_load_if_chk #(
  .ADDR_W(ADDR_W), .DATA_W(WORD_W-ADDR_W), .CAL_ADDR(CAL_ADDR), .PWR_BITS(PWR_BITS)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .cal_start (cal_start),
  .soft_rst  (soft_rst),
  .pwr_en    (pwr_en),
  .regs_flat (regs_flat)
);

// File: tb/test_sreg_load_if.sv
`timescale 1ns/1ps
module test_sreg_load_if;
  localparam int DW = 20;
  localparam int NS = 16;
  localparam int NV = 9;
  // {data[19:0], addr[3:0], slot checked[3:0], expected[19:0], cal pulse expected}
  localparam logic [48:0] VEC [NV] = '{
    {20'hABCDE, 4'h1, 4'h1, 20'hABCDE, 1'b0},  // R1 R2
    {20'h12345, 4'hC, 4'hC, 20'h12345, 1'b0},  // R3 slot 12 exists
    {20'hFFFFF, 4'h9, 4'h9, 20'hFFFFF, 1'b0},
    {20'h00001, 4'h0, 4'h0, 20'h00001, 1'b1},  // R5
    {20'h00001, 4'h0, 4'h0, 20'h00001, 1'b1},  // R5 same value again
    {20'h5A5A5, 4'h3, 4'h3, 20'h5A5A5, 1'b0},
    {20'hFFFFF, 4'hA, 4'h3, 20'h5A5A5, 1'b0},  // R3 unmapped address
    {20'h77777, 4'hD, 4'hD, 20'h00000, 1'b0},  // R3 unmapped address
    {20'h0007F, 4'h5, 4'h5, 20'h0007F, 1'b0}   // R10
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic [NS*DW-1:0] regs_flat;
  logic [6:0] pwr_en;
  logic soft_rst, cal_start;

  int n_chk = 0, n_fail = 0, cal_cnt = 0, cal_double = 0;
  logic prev_cal = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sreg_load_if i_sreg_load_if (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch),
    .regs_flat(regs_flat), .pwr_en(pwr_en), .soft_rst(soft_rst), .cal_start(cal_start)
  );

  always @(negedge clk) begin
    if (!rst && cal_start) cal_cnt++;
    if (!rst && cal_start && prev_cal) cal_double++;
    prev_cal <= cal_start;
  end

  function automatic logic [DW-1:0] slot(input int a);
    return regs_flat[a*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] dflt(input int a);
    if (a == 5 || a == 10 || a == 11 || a > 12) return '0;
    return {a[3:0], 16'h0000};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      ser_data = v[k];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    repeat (4) @(negedge clk);
    ser_latch = 1'b1;
    repeat (12) @(negedge clk);
    ser_latch = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(input logic [23:0] w);
    send_bits({40'h0, w}, 24);
    pulse_latch();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R9: reset defaults
    for (int a = 0; a < NS; a++) check($sformatf("R9 slot %0d default", a), slot(a), dflt(a));
    check("R9 soft_rst low", soft_rst, 0);
    check("R9 pwr_en zero", pwr_en, 0);
    check("R9 no cal pulse", cal_cnt, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      c0 = cal_cnt;
      write_word(VEC[v][48:25]);
      check($sformatf("R2 vector %0d slot", v), slot(int'(VEC[v][24:21])), VEC[v][20:1]);
      check($sformatf("R5 vector %0d cal count", v), cal_cnt - c0, VEC[v][0]);
    end
    check("R10 pwr_en all on", pwr_en, 7'h7F);
    check("R3 slot 10 zero", slot(10), 0);
    check("R3 slot 13 zero", slot(13), 0);

    // R4: over-long stream keeps the last 24 bits
    send_bits({32'h0, 8'hC3, 20'h2468A, 4'h2}, 32);
    pulse_latch();
    check("R4 last 24 bits kept", slot(2), 20'h2468A);

    // R1: shift clocks while latch high are ignored
    write_word({20'h13579, 4'h7});
    c0 = cal_cnt;
    ser_latch = 1'b1;
    repeat (8) @(negedge clk);
    send_bits(64'h0, 4);
    ser_latch = 1'b0;
    repeat (8) @(negedge clk);
    ser_latch = 1'b1;
    repeat (12) @(negedge clk);
    ser_latch = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 slot 0 untouched", slot(0), 20'h00001);
    check("R1 slot 7 kept", slot(7), 20'h13579);
    check("R1 no cal pulse", cal_cnt - c0, 0);

    // R6: soft reset
    c0 = cal_cnt;
    write_word({20'h8007F, 4'h5});
    check("R6 soft_rst high", soft_rst, 1);
    check("R6 pwr_en off", pwr_en, 0);
    check("R6 slot 5 value", slot(5), 20'h80000);
    check("R6 slot 1 default", slot(1), 20'h10000);
    check("R6 slot 0 default", slot(0), 20'h00000);
    check("R6 slot 12 default", slot(12), 20'hC0000);
    check("R6 slot 2 default", slot(2), 20'h20000);

    // R8: writes ignored while held
    write_word({20'h22222, 4'h1});
    check("R8 slot 1 held", slot(1), 20'h10000);
    write_word({20'h00003, 4'h0});
    check("R8 slot 0 held", slot(0), 20'h00000);
    check("R8 no cal pulse", cal_cnt - c0, 0);

    // R7: release keeps defaults, second write enables
    write_word({20'h0007F, 4'h5});
    check("R7 soft_rst released", soft_rst, 0);
    check("R7 slot 5 zero", slot(5), 0);
    check("R7 pwr_en still off", pwr_en, 0);
    write_word({20'h00055, 4'h5});
    check("R7 slot 5 enabled", slot(5), 20'h00055);
    check("R10 pwr_en pattern", pwr_en, 7'h55);

    c0 = cal_cnt;
    write_word({20'h00002, 4'h0});
    check("R5 cal after release", cal_cnt - c0, 1);
    check("R5 slot 0 written", slot(0), 20'h00002);
    check("R5 pulses single cycle", cal_double, 0);

    finish_run();
  end
endmodule